// File: doc/BRIEF.md
# DMA Channel Register Port Interface

This block is the processor-facing register front end of a four-channel DMA controller. Every channel keeps a 16-bit memory address register and a 16-bit transfer count register. The processor reaches them only through 8-bit I/O ports. A single byte pointer, shared by all eight registers, decides whether an access lands on the low or the high byte. A separate port puts that pointer back to the low byte. The register values leave the block on flat vectors so that the transfer engine can use them.

The parameter `SPACED` picks one of two port layouts. In packed mode the sixteen register selects sit on consecutive ports from `PORT_BASE`. In spaced mode the controller is wired from address bit 1, so the selects are two ports apart, the window spans 32 ports and address bit 0 is ignored. Requests arrive on a valid/ready channel. A request is taken on a cycle where `bus_valid` and `bus_ready` are both high, and the requester holds its fields steady until then. Each accepted read returns one byte on a valid/ready response channel. `bus_ready` drops while a response is waiting with `rsp_ready` low, and this back-pressure is the only reason requests stall.

Top module: `dma_port_regs`

## Requirements
- R1: After reset, all address and count registers are zero, the byte pointer selects the low byte, and no response is pending.
- R2: With SPACED=0, the register select is address bits 3..0 inside the 16-port window at PORT_BASE. Select 2n is channel n's address register, select 2n+1 its count register, and select 0xC is the pointer-clear port.
- R3: With SPACED=1, the register select is address bits 4..1 inside the 32-port window at PORT_BASE, and bit 0 is ignored. Channel n's address register is at PORT_BASE+4n, its count register at PORT_BASE+4n+2, and the pointer-clear port at PORT_BASE+0x18.
- R4: The first register access after reset or a clear targets bits 7..0, and the next targets bits 15..8. The pointer alternates on every register access, and one pointer is shared across all channels and both register kinds.
- R5: A read of an address or count port advances the byte pointer exactly like a write does.
- R6: A write to the pointer-clear port sets the pointer to the low byte, whatever the data value.
- R7: An access outside the window, a read of the clear port, or an access to any other select in the window (8..0xB, 0xD..0xF) leaves every register and the pointer unchanged. Such a read returns 0x00.
- R8: An accepted read raises `rsp_valid` on the next cycle, carrying the byte of the selected register that the pointer chose at acceptance.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `bus_ready` is low and `rsp_data` and `rsp_valid` stay unchanged.
- R10: A register write changes only the addressed byte of the addressed register. The other byte and all other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present |
| bus_ready | output | 1 | Request can be taken this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | I/O port address |
| bus_wdata | input | DATA_W (8) | Write byte |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Response consumer can take the byte |
| rsp_data | output | DATA_W (8) | Read byte |
| chan_addr | output | NUM_CH*2*DATA_W (64) | Address registers, channel 0 in the low 16 bits |
| chan_count | output | NUM_CH*2*DATA_W (64) | Count registers, channel 0 in the low 16 bits |

## Verification
The assertions assume a synchronous reset held for at least one edge and request fields with known values. They also assume that the only thing qualifying a request is `bus_valid` together with `bus_ready`, so the pointer and registers may move only on an accepted request. The stimulus drives every request away from the clock edge and holds it until it is accepted. It changes `rsp_ready` only between edges and stalls the response channel on purpose exactly once. Two copies of the block, one packed at 0x00 and one spaced at 0xC0, share one request stream. Their windows do not overlap, so every request is also an out-of-window access for the other copy.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;
  localparam int unsigned SEL_W = 4;
  localparam logic [SEL_W-1:0] CLR_SEL = 4'hC;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_REG  = 2'd1,
    ACC_CLR  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_CH    = 4,
  parameter bit          SPACED    = 1'b0,
  parameter int unsigned PORT_BASE = 0,
  localparam int unsigned CH_W     = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [CH_W-1:0]   ch,
  output logic              is_cnt
);
  localparam int unsigned WIN_LSB = SEL_W + (SPACED ? 1 : 0);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(PORT_BASE);
  localparam logic [SEL_W-1:0] REG_LIMIT = SEL_W'(2 * NUM_CH);

  logic [SEL_W-1:0] sel;
  logic             in_win;

  generate
    if (SPACED) begin : g_spaced
      logic unused_lsb;
      assign unused_lsb = addr[0];
      assign sel = addr[SEL_W:1];
    end else begin : g_packed
      assign sel = addr[SEL_W-1:0];
    end
  endgenerate

  assign in_win = (addr[ADDR_W-1:WIN_LSB] == BASE_V[ADDR_W-1:WIN_LSB]);

  always_comb begin
    kind = ACC_NONE;
    if (in_win) begin
      if (sel < REG_LIMIT) kind = ACC_REG;
      else if (sel == CLR_SEL) kind = ACC_CLR;
    end
  end

  assign ch     = sel[CH_W:1];
  assign is_cnt = sel[0];
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  output logic hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) hi <= 1'b0;
    else if (clear) hi <= 1'b0;
    else if (step) hi <= ~hi;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned REG_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_addr,
  input  logic              we_cnt,
  input  logic              hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [REG_W-1:0]  addr_q,
  output logic [REG_W-1:0]  cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (we_addr) begin
        if (hi) addr_q[REG_W-1:DATA_W] <= wdata;
        else    addr_q[DATA_W-1:0]     <= wdata;
      end
      if (we_cnt) begin
        if (hi) cnt_q[REG_W-1:DATA_W] <= wdata;
        else    cnt_q[DATA_W-1:0]     <= wdata;
      end
    end
  end
endmodule

// File: rtl/dma_port_regs.sv
module dma_port_regs
  import dma_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_CH    = 4,
  parameter bit          SPACED    = 1'b0,
  parameter int unsigned PORT_BASE = 0,
  localparam int unsigned REG_W    = 2 * DATA_W,
  localparam int unsigned CH_W     = $clog2(NUM_CH),
  localparam int unsigned VEC_W    = NUM_CH * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [VEC_W-1:0]  chan_addr,
  output logic [VEC_W-1:0]  chan_count
);
  acc_kind_e       kind;
  logic [CH_W-1:0] ch;
  logic            is_cnt;
  logic            accept;
  logic            reg_hit;
  logic            clr_hit;
  logic            ptr_hi;
  logic [REG_W-1:0] rd_reg;
  logic [DATA_W-1:0] rd_byte;
  logic [NUM_CH-1:0][REG_W-1:0] addr_arr;
  logic [NUM_CH-1:0][REG_W-1:0] cnt_arr;

  dma_port_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SPACED(SPACED), .PORT_BASE(PORT_BASE)
  ) u_decode (
    .addr(bus_addr), .kind(kind), .ch(ch), .is_cnt(is_cnt)
  );

  // A pending response that cannot leave blocks new requests.
  assign bus_ready = ~(rsp_valid & ~rsp_ready);
  assign accept    = bus_valid & bus_ready;
  assign reg_hit   = accept & (kind == ACC_REG);
  assign clr_hit   = accept & bus_write & (kind == ACC_CLR);

  dma_byte_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .step(reg_hit), .clear(clr_hit), .hi(ptr_hi)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      logic sel_me;
      assign sel_me = reg_hit & bus_write & (ch == CH_W'(g));
      dma_chan_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_addr(sel_me & ~is_cnt), .we_cnt(sel_me & is_cnt),
        .hi(ptr_hi), .wdata(bus_wdata),
        .addr_q(addr_arr[g]), .cnt_q(cnt_arr[g])
      );
    end
  endgenerate

  assign chan_addr  = addr_arr;
  assign chan_count = cnt_arr;

  always_comb begin
    rd_reg  = is_cnt ? cnt_arr[ch] : addr_arr[ch];
    rd_byte = '0;
    if (kind == ACC_REG) rd_byte = ptr_hi ? rd_reg[REG_W-1:DATA_W] : rd_reg[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !bus_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_port_regs_chk.sv
module dma_port_regs_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned VEC_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              bus_ready,
  input logic              bus_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [VEC_W-1:0]  chan_addr,
  input logic [VEC_W-1:0]  chan_count,
  input logic              reg_hit,
  input logic              clr_hit,
  input logic              ptr_hi
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ptr_hi && !rsp_valid && chan_addr == '0 && chan_count == '0));

  assert_ptr_alternates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |=> (ptr_hi != $past(ptr_hi)));

  assert_clear_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !ptr_hi);

  assert_ptr_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_hit && !clr_hit) |=> $stable(ptr_hi));

  assert_read_response_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bus_write) |=> rsp_valid);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_no_accept_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !accept);

  assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && bus_write) |=> ($stable(chan_addr) && $stable(chan_count)));

  wire unused_ready = bus_ready;
endmodule

bind dma_port_regs dma_port_regs_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .bus_ready(bus_ready),
  .bus_write(bus_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .chan_addr(chan_addr), .chan_count(chan_count),
  .reg_hit(reg_hit), .clr_hit(clr_hit), .ptr_hi(ptr_hi)
);

// File: tb/test_dma_port_regs.sv
`timescale 1ns/1ps
module test_dma_port_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, rsp_ready = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic rdy0, rdy1, rv0, rv1;
  logic [7:0] rd0, rd1;
  logic [63:0] ca0, cc0, ca1, cc1;
  logic bus_ready;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  assign bus_ready = rdy0 & rdy1;

  dma_port_regs #(.SPACED(1'b0), .PORT_BASE(16'h0000)) i_dma_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(rdy0),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rv0), .rsp_ready(rsp_ready), .rsp_data(rd0),
    .chan_addr(ca0), .chan_count(cc0));

  dma_port_regs #(.SPACED(1'b1), .PORT_BASE(16'h00C0)) i_dma_port_regs_sp (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(rdy1),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rv1), .rsp_ready(rsp_ready), .rsp_data(rd1),
    .chan_addr(ca1), .chan_count(cc1));

  // Reference model: index 0 = packed copy, 1 = spaced copy.
  logic [15:0] m_addr [2][4];
  logic [15:0] m_cnt  [2][4];
  bit          m_ptr  [2];

  typedef struct { logic [7:0] e0; logic [7:0] e1; string req; } exp_t;
  exp_t sb[$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic model(bit wr, logic [15:0] a, logic [7:0] d, output logic [7:0] r0, output logic [7:0] r1);
    for (int m = 0; m < 2; m++) begin
      bit hit; int sel; logic [7:0] r;
      hit = (m == 0) ? (a[15:4] == 12'h000) : (a[15:5] == 11'h006);
      sel = (m == 0) ? int'(a[3:0]) : int'(a[4:1]);
      r = 8'h00;
      if (hit && sel < 8) begin
        int ch; ch = sel / 2;
        if (sel % 2 == 0) begin
          if (wr) begin if (m_ptr[m]) m_addr[m][ch][15:8] = d; else m_addr[m][ch][7:0] = d; end
          r = m_ptr[m] ? m_addr[m][ch][15:8] : m_addr[m][ch][7:0];
        end else begin
          if (wr) begin if (m_ptr[m]) m_cnt[m][ch][15:8] = d; else m_cnt[m][ch][7:0] = d; end
          r = m_ptr[m] ? m_cnt[m][ch][15:8] : m_cnt[m][ch][7:0];
        end
        m_ptr[m] = ~m_ptr[m];
      end else if (hit && sel == 12 && wr) begin
        m_ptr[m] = 1'b0;
      end
      if (m == 0) r0 = r; else r1 = r;
    end
  endtask

  task automatic access(bit wr, logic [15:0] a, logic [7:0] d, string req);
    logic [7:0] r0, r1;
    exp_t e;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    bus_valid = 1'b0;
    model(wr, a, d, r0, r1);
    if (!wr) begin e.e0 = r0; e.e1 = r1; e.req = req; sb.push_back(e); end
  endtask

  task automatic check_regs(string req);
    logic [63:0] a0, c0, a1, c1;
    @(negedge clk); #1;
    for (int c = 0; c < 4; c++) begin
      a0[c*16 +: 16] = m_addr[0][c]; c0[c*16 +: 16] = m_cnt[0][c];
      a1[c*16 +: 16] = m_addr[1][c]; c1[c*16 +: 16] = m_cnt[1][c];
    end
    chk({req, " packed addr"}, ca0, a0);
    chk({req, " packed count"}, cc0, c0);
    chk({req, " spaced addr"}, ca1, a1);
    chk({req, " spaced count"}, cc1, c1);
  endtask

  // Monitor: pops an expectation on each response handshake.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rv0 && rsp_ready) begin
        if (sb.size() == 0) chk("R8 unexpected response", 64'(rv0), 64'(0));
        else begin
          exp_t e; e = sb.pop_front();
          chk({e.req, " packed read"}, 64'(rd0), 64'(e.e0));
          chk({e.req, " spaced read"}, 64'(rd1), 64'(e.e1));
          chk({e.req, " response pairing"}, 64'(rv1), 64'(1));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      m_ptr[m] = 1'b0;
      for (int c = 0; c < 4; c++) begin m_addr[m][c] = '0; m_cnt[m][c] = '0; end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk("R1 rsp_valid", 64'({rv0, rv1}), 64'(0));
    chk("R1 bus_ready", 64'(bus_ready), 64'(1));
    check_regs("R1");
    access(1'b0, 16'h0001, 8'h00, "R1 pointer low");
    // R2 packed map with R4 byte order
    access(1'b1, 16'h000C, 8'hA5, "R6");
    access(1'b1, 16'h0004, 8'h34, "R2");
    access(1'b1, 16'h0004, 8'h12, "R2");
    access(1'b1, 16'h0005, 8'h78, "R2");
    access(1'b1, 16'h0005, 8'h56, "R2");
    check_regs("R2 ch2 words");
    // R3 spaced map, bit 0 ignored
    access(1'b1, 16'h00D8, 8'h3C, "R3");
    access(1'b1, 16'h00C4, 8'hCD, "R3");
    access(1'b1, 16'h00C5, 8'hAB, "R3");
    access(1'b1, 16'h00CE, 8'h11, "R3");
    access(1'b1, 16'h00CE, 8'h22, "R3");
    check_regs("R3 spaced words");
    // R8 reads follow the pointer
    access(1'b1, 16'h000C, 8'h00, "R6");
    access(1'b0, 16'h0004, 8'h00, "R8 low byte");
    access(1'b0, 16'h0004, 8'h00, "R8 high byte");
    access(1'b0, 16'h0005, 8'h00, "R8 count low");
    access(1'b1, 16'h00D8, 8'h00, "R6");
    access(1'b0, 16'h00C5, 8'h00, "R8 spaced low");
    access(1'b0, 16'h00C4, 8'h00, "R8 spaced high");
    // R5: read advances pointer, next write goes high
    access(1'b1, 16'h000C, 8'h00, "R6");
    access(1'b0, 16'h0000, 8'h00, "R5 read step");
    access(1'b1, 16'h0000, 8'h99, "R5");
    check_regs("R5 write after read");
    // R6: clear mid-pair with nonzero data
    access(1'b1, 16'h0002, 8'h11, "R6");
    access(1'b1, 16'h000C, 8'hFF, "R6");
    access(1'b1, 16'h0002, 8'h22, "R6");
    check_regs("R6 clear mid pair");
    // R4: pointer shared across channels and kinds
    access(1'b1, 16'h0007, 8'h44, "R4 shared pointer");
    check_regs("R4 shared pointer");
    // R7: ignored accesses
    access(1'b1, 16'h0008, 8'h55, "R7");
    access(1'b1, 16'h000F, 8'h66, "R7");
    access(1'b1, 16'h0040, 8'h77, "R7");
    access(1'b0, 16'h000E, 8'h00, "R7 in-window read");
    access(1'b0, 16'h000C, 8'h00, "R7 clear port read");
    access(1'b0, 16'h0123, 8'h00, "R7 outside read");
    access(1'b1, 16'h00DA, 8'h88, "R7");
    check_regs("R7 no change");
    access(1'b1, 16'h0006, 8'hE1, "R7 pointer kept");
    check_regs("R7 pointer kept");
    // R10: byte-local writes
    access(1'b1, 16'h000C, 8'h00, "R6");
    access(1'b1, 16'h00C0, 8'h5A, "R10");
    check_regs("R10 one byte");
    // R9: back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    access(1'b0, 16'h0004, 8'h00, "R9 held read");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R9 bus_ready low", 64'(bus_ready), 64'(0));
      chk("R9 rsp_data held", 64'(rd0), 64'(sb[0].e0));
      chk("R9 rsp_valid held", 64'(rv0), 64'(1));
    end
    @(negedge clk); rsp_ready = 1'b1;
    access(1'b0, 16'h0004, 8'h00, "R9 after stall");
    repeat (4) @(negedge clk);
    chk("R8 scoreboard drained", 64'(sb.size()), 64'(0));
    finish_run();
  end
endmodule